// File: doc/BRIEF.md
# Doorbell Interrupt I/O Window

This block is a small register window in I/O space. It occupies 32 consecutive byte addresses. The window's base address and a decode-enable flag come from the device's configuration logic. When the host accesses the window, the block answers with fixed identity bytes or with the configured interrupt routing values. It also offers one doorbell location. Software writes the doorbell to raise a level interrupt request. It reads the same location to learn whether the request was pending and to acknowledge it.

Accesses are handled one per clock on single-cycle read and write strobes. Read data and the hit indication are combinational from the current access. The doorbell state is a single registered flag, and the interrupt request output follows that flag directly. Wider accesses behave as byte accesses on the lowest lane: only write data bits 7:0 matter, and read data is the byte zero-extended.

Top module: `doorbell_window`

## Requirements
- R1: `hit` is high exactly when a read or write strobe is active, `cfg_decode_en` is high, and `io_addr[15:5]` equals `cfg_base[15:5]`. Bits 4:0 of `cfg_base` are ignored, and `io_addr[4:0]` is the window offset.
- R2: A read hit at offsets 0, 1, 2 and 3 returns 0x1A, 0x07, 0x0B and 0xAB respectively.
- R3: A read hit at offset 4 returns `cfg_int_line`. A read hit at offset 5 returns `cfg_int_pin`.
- R4: A write hit at offset 6, with any data, sets the pending flag when it is clear. `irq` is high from the following cycle on.
- R5: A read hit at offset 6 returns the pending flag in bit 0 as it was before the access. It clears the flag, so `irq` is low from the following cycle.
- R6: Bits 31:8 of `io_wdata` have no effect, and bits 31:8 of `io_rdata` are always zero.
- R7: A read hit at offsets 7 through 31 returns zero. Writes to any offset other than 6 leave `irq` unchanged.
- R8: After reset `irq` is low.
- R9: When a read and a write to offset 6 hit in the same cycle, the read wins. It returns the old flag, and `irq` is low afterwards.
- R10: An access outside the window, or any access while `cfg_decode_en` is low, gives `hit` low and `io_rdata` zero, and leaves `irq` unchanged.
- R11: A write hit at offset 6 while the flag is already set keeps it set. A single acknowledging read then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O byte address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 32 | Write data, only bits 7:0 used |
| cfg_base | input | 16 | Window base address from configuration |
| cfg_decode_en | input | 1 | Decode enable from configuration |
| cfg_int_line | input | 8 | Interrupt line value to report |
| cfg_int_pin | input | 8 | Interrupt pin value to report |
| io_rdata | output | 32 | Read data, byte zero-extended |
| hit | output | 1 | Current access falls inside the enabled window |
| irq | output | 1 | Level interrupt request, equal to the pending flag |

## Verification
The only internal state is the pending flag, and it drives `irq` directly. A wrong flag therefore shows on `irq` one cycle after the access that corrupted it. It shows again in bit 0 of the next doorbell read. A decode fault shows at once on `hit` and `io_rdata` in the cycle of the access. It can also show as a doorbell state change caused by an address that should have missed, one cycle later.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    // Window offset bits and decoded offsets with behaviour
    localparam int WIN_BITS = 5;
    localparam logic [WIN_BITS-1:0] OFS_LINE  = 5'd4;
    localparam logic [WIN_BITS-1:0] OFS_PIN   = 5'd5;
    localparam logic [WIN_BITS-1:0] OFS_BELL  = 5'd6;
    localparam int ID_COUNT = 4;

    // Identity bytes, lowest offset in the lowest byte
    localparam logic [31:0] ID_WORD = 32'hAB0B_071A;

    typedef struct packed {
        logic pending;
    } bell_state_t;

    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        return ID_WORD[8*idx +: 8];
    endfunction

endpackage

// File: rtl/window_decode.sv
module window_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W-1:0]   base,
    input  logic                decode_en,
    input  logic                rd,
    input  logic                wr,
    output logic                hit,
    output logic                rd_hit,
    output logic                wr_hit,
    output logic [WIN_BITS-1:0] offset
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0] addr_tag;
    logic [TAG_W-1:0] base_tag;
    logic             in_window;
    logic             unused_base_low;

    assign addr_tag        = addr[ADDR_W-1:WIN_BITS];
    assign base_tag        = base[ADDR_W-1:WIN_BITS];
    assign unused_base_low = ^base[WIN_BITS-1:0];

    always_comb begin
        in_window = decode_en && (addr_tag == base_tag);
        rd_hit    = in_window && rd;
        wr_hit    = in_window && wr;
        hit       = rd_hit || wr_hit;
        offset    = addr[WIN_BITS-1:0];
    end

    // R10: no hit while decoding is disabled
    p_no_hit_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !decode_en |-> !hit);

    // R1: a hit always comes from a strobe
    p_hit_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rd || wr));

endmodule

// File: rtl/read_mux.sv
module read_mux #(
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_hit,
    input  logic [WIN_BITS-1:0] offset,
    input  logic [7:0]          int_line,
    input  logic [7:0]          int_pin,
    input  logic                pending,
    output logic [DATA_W-1:0]   rdata
);
    import doorbell_pkg::*;

    logic [7:0] byte_v;

    always_comb begin
        byte_v = 8'h00;
        if (rd_hit) begin
            if (offset < WIN_BITS'(ID_COUNT)) begin
                byte_v = id_byte(offset[1:0]);
            end else if (offset == OFS_LINE) begin
                byte_v = int_line;
            end else if (offset == OFS_PIN) begin
                byte_v = int_pin;
            end else if (offset == OFS_BELL) begin
                byte_v = {7'd0, pending};
            end
        end
    end

    generate
        if (DATA_W > 8) begin : g_wide
            assign rdata = {{(DATA_W-8){1'b0}}, byte_v};
        end else begin : g_byte
            assign rdata = byte_v[DATA_W-1:0];
        end
    endgenerate

    // R10: no read data without a read hit
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rdata == '0));

    // R5: doorbell read reports at most one bit
    p_bell_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && offset == OFS_BELL) |-> (rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl #(
    parameter int WIN_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_hit,
    input  logic                wr_hit,
    input  logic [WIN_BITS-1:0] offset,
    output logic                pending
);
    import doorbell_pkg::*;

    bell_state_t st_d, st_q;
    logic        at_bell;

    assign at_bell = (offset == OFS_BELL);

    always_comb begin
        st_d = st_q;
        if (rd_hit && at_bell) begin
            st_d.pending = 1'b0;
        end else if (wr_hit && at_bell && !st_q.pending) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pending;

    // R4: a lone doorbell write leaves the flag set
    p_set_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && at_bell && !rd_hit) |=> pending);

    // R5 / R9: a doorbell read always leaves the flag clear
    p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && at_bell) |=> !pending);

    // R7 / R10: the flag holds without a doorbell hit
    p_hold_otherwise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_hit || wr_hit) || !at_bell) |=> $stable(pending));

endmodule

// File: rtl/doorbell_window.sv
module doorbell_window #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_decode_en,
    input  logic [7:0]        cfg_int_line,
    input  logic [7:0]        cfg_int_pin,
    output logic [DATA_W-1:0] io_rdata,
    output logic              hit,
    output logic              irq
);
    import doorbell_pkg::*;

    logic                rd_hit;
    logic                wr_hit;
    logic [WIN_BITS-1:0] offset;
    logic                pending;
    logic                unused_wdata;

    // Write data content never matters: any value rings the doorbell
    assign unused_wdata = ^io_wdata;

    window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (io_addr),
        .base      (cfg_base),
        .decode_en (cfg_decode_en),
        .rd        (io_rd),
        .wr        (io_wr),
        .hit       (hit),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit),
        .offset    (offset)
    );

    doorbell_ctrl #(.WIN_BITS(WIN_BITS)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit),
        .offset  (offset),
        .pending (pending)
    );

    read_mux #(.DATA_W(DATA_W), .WIN_BITS(WIN_BITS)) mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .offset   (offset),
        .int_line (cfg_int_line),
        .int_pin  (cfg_int_pin),
        .pending  (pending),
        .rdata    (io_rdata)
    );

    assign irq = pending;

    // R6: upper read lanes stay zero
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[DATA_W-1:8] == '0);

    // R10: a miss never moves the interrupt request
    p_miss_keeps_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(irq));

endmodule

// File: tb/doorbell_window_tb_top.sv
module doorbell_window_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [15:0] cfg_base = 16'h0340;
    logic        cfg_decode_en = 1'b1;
    logic [7:0]  cfg_int_line = 8'h0B;
    logic [7:0]  cfg_int_pin = 8'h04;
    logic [31:0] io_rdata;
    logic        hit;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic        got_hit;
    logic [31:0] got_data;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    doorbell_window dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .cfg_base(cfg_base), .cfg_decode_en(cfg_decode_en),
        .cfg_int_line(cfg_int_line), .cfg_int_pin(cfg_int_pin),
        .io_rdata(io_rdata), .hit(hit), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at falling edge, sample mid-cycle, release after the rising edge
    task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                          input logic [31:0] wd);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd;
        #1;
        got_hit = hit;
        got_data = io_rdata;
        @(posedge clk);
        #1;
        io_rd = 1'b0; io_wr = 1'b0; io_wdata = '0;
    endtask

    task automatic t_reset;
        #1;
        check("R8 irq at reset", 32'(irq), 32'd0);
        check("R1 no hit idle", 32'(hit), 32'd0);
    endtask

    task automatic t_identity;
        logic [7:0] ids [4] = '{8'h1A, 8'h07, 8'h0B, 8'hAB};
        for (int i = 0; i < 4; i++) begin
            access(16'h0340 + 16'(i), 1'b1, 1'b0, '0);
            check("R1 hit on identity read", 32'(got_hit), 32'd1);
            check("R2 identity byte", got_data, 32'(ids[i]));
        end
    endtask

    task automatic t_cfg_values;
        access(16'h0344, 1'b1, 1'b0, '0);
        check("R3 line value", got_data, 32'h0B);
        cfg_int_pin = 8'h01;
        access(16'h0345, 1'b1, 1'b0, '0);
        check("R3 pin value", got_data, 32'h01);
    endtask

    task automatic t_doorbell;
        access(16'h0346, 1'b0, 1'b1, 32'h0000_0055);
        check("R1 hit on write", 32'(got_hit), 32'd1);
        check("R4 irq after set", 32'(irq), 32'd1);
        access(16'h0346, 1'b1, 1'b0, '0);
        check("R5 read returns flag", got_data, 32'd1);
        check("R5 irq after ack", 32'(irq), 32'd0);
        access(16'h0346, 1'b1, 1'b0, '0);
        check("R5 second read empty", got_data, 32'd0);
    endtask

    task automatic t_double_set;
        access(16'h0346, 1'b0, 1'b1, 32'h1);
        access(16'h0346, 1'b0, 1'b1, 32'h2);
        check("R11 still pending", 32'(irq), 32'd1);
        access(16'h0346, 1'b1, 1'b0, '0);
        check("R11 single ack value", got_data, 32'd1);
        check("R11 single ack clears", 32'(irq), 32'd0);
    endtask

    task automatic t_wide;
        access(16'h0346, 1'b0, 1'b1, 32'hFFFF_FF00);
        check("R6 upper data ignored, still sets", 32'(irq), 32'd1);
        access(16'h0346, 1'b1, 1'b0, '0);
        check("R6 zero-extended read", got_data, 32'h0000_0001);
    endtask

    task automatic t_other_offsets;
        access(16'h0347, 1'b1, 1'b0, '0);
        check("R7 offset 7 reads zero", got_data, 32'd0);
        access(16'h035F, 1'b1, 1'b0, '0);
        check("R7 offset 31 reads zero", got_data, 32'd0);
        access(16'h0347, 1'b0, 1'b1, 32'hFF);
        check("R7 write offset 7 no set", 32'(irq), 32'd0);
        access(16'h0346, 1'b0, 1'b1, 32'h1);
        access(16'h0340, 1'b0, 1'b1, 32'h1);
        check("R7 write offset 0 keeps irq", 32'(irq), 32'd1);
        access(16'h0344, 1'b0, 1'b1, 32'h77);
        access(16'h0344, 1'b1, 1'b0, '0);
        check("R7 line not writable", got_data, 32'h0B);
    endtask

    task automatic t_miss;
        // pending is set on entry
        access(16'h0360, 1'b1, 1'b0, '0);
        check("R10 beyond window no hit", 32'(got_hit), 32'd0);
        check("R10 beyond window data", got_data, 32'd0);
        access(16'h0366, 1'b1, 1'b0, '0);
        check("R10 outside read keeps irq", 32'(irq), 32'd1);
        cfg_decode_en = 1'b0;
        access(16'h0346, 1'b1, 1'b0, '0);
        check("R10 disabled no hit", 32'(got_hit), 32'd0);
        check("R10 disabled data", got_data, 32'd0);
        check("R10 disabled keeps irq", 32'(irq), 32'd1);
        cfg_decode_en = 1'b1;
        access(16'h0346, 1'b1, 1'b0, '0);
        check("R5 ack after re-enable", 32'(irq), 32'd0);
        cfg_decode_en = 1'b0;
        access(16'h0346, 1'b0, 1'b1, 32'h1);
        check("R10 disabled write ignored", 32'(irq), 32'd0);
        cfg_decode_en = 1'b1;
        access(16'h033F, 1'b0, 1'b1, 32'h1);
        check("R10 below window no hit", 32'(got_hit), 32'd0);
    endtask

    task automatic t_collide;
        access(16'h0346, 1'b1, 1'b1, 32'h1);
        check("R9 clear flag collide data", got_data, 32'd0);
        check("R9 clear flag collide irq", 32'(irq), 32'd0);
        access(16'h0346, 1'b0, 1'b1, 32'h1);
        access(16'h0346, 1'b1, 1'b1, 32'h1);
        check("R9 set flag collide data", got_data, 32'd1);
        check("R9 read wins", 32'(irq), 32'd0);
    endtask

    task automatic t_base_low_bits;
        cfg_base = 16'h1237;
        access(16'h1220, 1'b1, 1'b0, '0);
        check("R1 base low bits ignored hit", 32'(got_hit), 32'd1);
        check("R1 base low bits ignored data", got_data, 32'h1A);
        access(16'h0340, 1'b1, 1'b0, '0);
        check("R1 old base misses", 32'(got_hit), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_identity();
        t_cfg_values();
        t_doorbell();
        t_double_set();
        t_wide();
        t_other_offsets();
        t_miss();
        t_collide();
        t_base_low_bits();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule